// File: doc/BRIEF.md
# DMA Channel Trigger Sequencer

This block decides when each DMA channel may begin moving a block of data and hands that decision to the transfer engine. Each channel can be started in two ways: by a one-clock software trigger, or by a hardware request line. A hardware request counts only while the channel's enable bit is set. Software writes that enable bit through a set port and a clear port. A per-channel auto-initiation bit chooses what happens when a block finishes. With the bit off, the channel drops its enable. With the bit on, the channel keeps its enable. A channel started by software then restarts by itself. A channel started by hardware waits for its next request.

One channel is active at a time. When several channels are ready, the lowest-numbered one wins. When a channel is granted, its stored configuration word (its control packet) is copied into a working register. A one-clock start pulse follows, carrying that working value to the engine. A hardware request that arrives while its channel is busy is held as pending. A bus error reported against the active channel ends its block, drops its enable and blocks any automatic restart.

Top module: `dma_trig_seq`

## Requirements
- R1: After reset, `hw_en`, `pend`, `busy` and `start` are all zero.
- R2: A one on bit i of `en_set` sets `hw_en[i]`, and a one on bit i of `en_clr` clears it. Bits written as zero keep their value. When both ports write a one to the same bit, the clear wins.
- R3: A `hw_req` bit that is sampled while its `hw_en` bit is zero is dropped. It sets no `pend` bit and causes no start.
- R4: A `hw_req` bit sampled while its channel is enabled sets `pend[i]` at that edge. If the sequencer is idle, `start` is high for exactly one cycle, two edges later, with `act_ch` equal to i (binary channel number). `busy` stays high from the grant until the block ends.
- R5: When `blk_done` is sampled while a block runs and the active channel's `aim` bit is zero, that channel's `hw_en` bit is zero from the next cycle on.
- R6: When a hardware-started block completes with `aim` set, `hw_en` stays set. No new start occurs until a new `hw_req` is sampled.
- R7: A `sw_trig` pulse starts its channel whatever its `hw_en` is, with the same two-edge timing as R4. If `aim` is set when the block completes, the channel restarts with no new trigger, `start` rising two edges after the `blk_done` edge. With `aim` clear it stays idle.
- R8: A `bus_err` sampled while a block runs ends the block. It clears the active channel's `hw_en` and pending request, and it prevents any automatic restart, even with `aim` set.
- R9: A `hw_req` for an enabled, busy channel is held in `pend` and started after the block ends if the channel is still enabled. If completion clears the enable, the pending request is discarded.
- R10: Among ready channels the lowest-numbered one is granted first, and only one block is active at a time.
- R11: `start_cfg` shows the channel's stored packet as it was at the edge after the grant, so a packet rewritten during a block takes effect at the next start. `start_cfg` does not change while a block runs.
- R12: `blk_done` and `bus_err` have no effect while no block is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sw_trig | input | NCH | Software trigger pulses, one bit per channel |
| hw_req | input | NCH | Hardware request pulses, one bit per channel |
| en_set | input | NCH | Write-one-to-set for the hardware enables |
| en_clr | input | NCH | Write-one-to-clear for the hardware enables |
| aim | input | NCH | Auto-initiation mode per channel |
| pkt_we | input | 1 | Control packet write strobe |
| pkt_sel | input | CHW | Channel whose packet is written |
| pkt_data | input | CFGW | Packet data to store |
| blk_done | input | 1 | Engine reports that the active block has completed |
| bus_err | input | 1 | Engine reports a bus error on the active block |
| start | output | 1 | One-cycle start pulse to the engine |
| act_ch | output | CHW | Active channel number |
| busy | output | 1 | A channel is granted or running |
| start_cfg | output | CFGW | Working configuration of the active channel |
| hw_en | output | NCH | Hardware enable status |
| pend | output | NCH | Pending status (software armed or hardware request held) |

## Verification
Every result has a fixed latency counted from the clock edge that samples the stimulus. Pending status and enable changes are visible one edge later. The grant (`busy`) follows one edge after that, and `start` with `start_cfg` and `act_ch` two edges after the sampling edge. An automatic restart also comes two edges after the `blk_done` edge. The bench drives each stimulus for one cycle from the falling edge and then steps an exact count of falling edges before it samples. Checks that nothing happened compare a count of start pulses, taken on rising edges, before and after a window several cycles longer than the restart latency.

// File: rtl/dma_trig_pkg.sv
package dma_trig_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_LOAD = 2'd1,
    SEQ_RUN  = 2'd2
  } seq_state_e;

endpackage

// File: rtl/dma_trig_arb.sv
module dma_trig_arb #(
  parameter int NCH = 4,
  parameter int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic [NCH-1:0] req,
  output logic           any,
  output logic [CHW-1:0] idx,
  output logic [NCH-1:0] onehot
);

  always_comb begin
    any    = |req;
    onehot = req & (~req + NCH'(1));
    idx    = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (req[i]) idx = CHW'(i);
    end
  end

  // R10: at most one channel granted in any cycle
  always_comb begin
    p_one_grant_r10: assert ($onehot0(onehot));
  end

endmodule

// File: rtl/dma_trig_chanctl.sv
module dma_trig_chanctl #(
  parameter int NCH = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] sw_trig,
  input  logic [NCH-1:0] hw_req,
  input  logic [NCH-1:0] en_set,
  input  logic [NCH-1:0] en_clr,
  input  logic [NCH-1:0] aim,
  input  logic [NCH-1:0] grant_vec,
  input  logic           grant_hw,
  input  logic [NCH-1:0] done_vec,
  input  logic [NCH-1:0] err_vec,
  input  logic           act_src_sw,
  output logic [NCH-1:0] hw_en,
  output logic [NCH-1:0] hw_pend,
  output logic [NCH-1:0] sw_arm,
  output logic [NCH-1:0] ready
);

  logic [NCH-1:0] en_d, en_we;
  logic [NCH-1:0] pend_d, arm_d;

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    always_comb begin
      en_we[i]  = en_set[i] | en_clr[i] | done_vec[i] | err_vec[i];
      en_d[i]   = (hw_en[i] | en_set[i]) & ~en_clr[i]
                  & ~(done_vec[i] & ~aim[i]) & ~err_vec[i];
      pend_d[i] = ((hw_pend[i] & ~(grant_vec[i] & grant_hw))
                   | (hw_req[i] & hw_en[i])) & en_d[i];
      arm_d[i]  = (sw_arm[i] & ~(grant_vec[i] & ~grant_hw))
                  | sw_trig[i]
                  | (done_vec[i] & aim[i] & act_src_sw);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        hw_en[i]   <= 1'b0;
        hw_pend[i] <= 1'b0;
        sw_arm[i]  <= 1'b0;
      end else begin
        if (en_we[i]) hw_en[i] <= en_d[i];
        hw_pend[i] <= pend_d[i];
        sw_arm[i]  <= arm_d[i];
      end
    end

    assign ready[i] = sw_arm[i] | (hw_pend[i] & hw_en[i]);

    // R3: a held hardware request always belongs to an enabled channel
    p_hw_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
      hw_pend[i] |-> hw_en[i]);

    // R5: completion without auto-initiation drops the enable
    p_auto_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (done_vec[i] && !aim[i]) |=> !hw_en[i]);

    // R6: completion with auto-initiation keeps the enable
    p_aim_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (done_vec[i] && aim[i] && !en_clr[i] && hw_en[i]) |=> hw_en[i]);
  end

endmodule

// File: rtl/dma_trig_pkt.sv
module dma_trig_pkt #(
  parameter int NCH  = 4,
  parameter int CFGW = 16,
  parameter int CHW  = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            pkt_we,
  input  logic [CHW-1:0]  pkt_sel,
  input  logic [CFGW-1:0] pkt_data,
  input  logic            load,
  input  logic [CHW-1:0]  load_sel,
  output logic [CFGW-1:0] work_cfg
);

  logic [CFGW-1:0] store_q [NCH];

  for (genvar i = 0; i < NCH; i++) begin : g_slot
    logic slot_we;
    assign slot_we = pkt_we && (pkt_sel == CHW'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       store_q[i] <= '0;
      else if (slot_we) store_q[i] <= pkt_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    work_cfg <= '0;
    else if (load) work_cfg <= store_q[load_sel];
  end

  // R11: the working copy only changes on a reload
  p_cfg_stable_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(work_cfg));

endmodule

// File: rtl/dma_trig_seq.sv
module dma_trig_seq #(
  parameter int NCH  = 4,
  parameter int CFGW = 16,
  parameter int CHW  = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NCH-1:0]  sw_trig,
  input  logic [NCH-1:0]  hw_req,
  input  logic [NCH-1:0]  en_set,
  input  logic [NCH-1:0]  en_clr,
  input  logic [NCH-1:0]  aim,
  input  logic            pkt_we,
  input  logic [CHW-1:0]  pkt_sel,
  input  logic [CFGW-1:0] pkt_data,
  input  logic            blk_done,
  input  logic            bus_err,
  output logic            start,
  output logic [CHW-1:0]  act_ch,
  output logic            busy,
  output logic [CFGW-1:0] start_cfg,
  output logic [NCH-1:0]  hw_en,
  output logic [NCH-1:0]  pend
);

  import dma_trig_pkg::*;

  seq_state_e     state_q, state_d;
  logic [CHW-1:0] act_q, act_d;
  logic           src_hw_q, src_hw_d;
  logic           start_d;
  logic           load;

  logic [NCH-1:0] hw_pend, sw_arm, ready;
  logic [NCH-1:0] grant_vec, done_vec, err_vec, arb_onehot;
  logic           arb_any;
  logic [CHW-1:0] arb_idx;

  dma_trig_arb #(.NCH(NCH), .CHW(CHW)) u_arb (
    .req    (ready),
    .any    (arb_any),
    .idx    (arb_idx),
    .onehot (arb_onehot)
  );

  always_comb begin
    state_d   = state_q;
    act_d     = act_q;
    src_hw_d  = src_hw_q;
    start_d   = 1'b0;
    load      = 1'b0;
    grant_vec = '0;
    done_vec  = '0;
    err_vec   = '0;
    case (state_q)
      SEQ_IDLE: begin
        if (arb_any) begin
          state_d   = SEQ_LOAD;
          act_d     = arb_idx;
          src_hw_d  = ~sw_arm[arb_idx];
          grant_vec = arb_onehot;
        end
      end
      SEQ_LOAD: begin
        load    = 1'b1;
        start_d = 1'b1;
        state_d = SEQ_RUN;
      end
      SEQ_RUN: begin
        if (bus_err) begin
          err_vec[act_q] = 1'b1;
          state_d        = SEQ_IDLE;
        end else if (blk_done) begin
          done_vec[act_q] = 1'b1;
          state_d         = SEQ_IDLE;
        end
      end
      default: state_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= SEQ_IDLE;
      act_q    <= '0;
      src_hw_q <= 1'b0;
      start    <= 1'b0;
    end else begin
      state_q <= state_d;
      start   <= start_d;
      if (state_q == SEQ_IDLE) begin
        act_q    <= act_d;
        src_hw_q <= src_hw_d;
      end
    end
  end

  dma_trig_chanctl #(.NCH(NCH)) u_chan (
    .clk        (clk),
    .rst_n      (rst_n),
    .sw_trig    (sw_trig),
    .hw_req     (hw_req),
    .en_set     (en_set),
    .en_clr     (en_clr),
    .aim        (aim),
    .grant_vec  (grant_vec),
    .grant_hw   (src_hw_d),
    .done_vec   (done_vec),
    .err_vec    (err_vec),
    .act_src_sw (~src_hw_q),
    .hw_en      (hw_en),
    .hw_pend    (hw_pend),
    .sw_arm     (sw_arm),
    .ready      (ready)
  );

  dma_trig_pkt #(.NCH(NCH), .CFGW(CFGW), .CHW(CHW)) u_pkt (
    .clk      (clk),
    .rst_n    (rst_n),
    .pkt_we   (pkt_we),
    .pkt_sel  (pkt_sel),
    .pkt_data (pkt_data),
    .load     (load),
    .load_sel (act_q),
    .work_cfg (start_cfg)
  );

  assign act_ch = act_q;
  assign busy   = (state_q != SEQ_IDLE);
  assign pend   = hw_pend | sw_arm;

  // R4: start lasts a single cycle
  p_start_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !start);

  // R10: a start only ever accompanies a granted, busy channel
  p_start_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> busy);

  // R8: a bus error on the running block clears its enable
  p_bus_err_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SEQ_RUN && bus_err) |=> !hw_en[$past(act_q)]);

  // R12: engine reports outside a running block leave the enables alone
  p_idle_ignore_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != SEQ_RUN && en_set == '0 && en_clr == '0) |=> $stable(hw_en));

endmodule

// File: tb/dma_trig_seq_bench.sv
module dma_trig_seq_bench;

  localparam int NCH  = 4;
  localparam int CFGW = 16;
  localparam int CHW  = 2;

  logic            clk = 1'b0;
  logic            rst_n;
  logic [NCH-1:0]  sw_trig, hw_req, en_set, en_clr, aim;
  logic            pkt_we;
  logic [CHW-1:0]  pkt_sel;
  logic [CFGW-1:0] pkt_data;
  logic            blk_done, bus_err;
  logic            start, busy;
  logic [CHW-1:0]  act_ch;
  logic [CFGW-1:0] start_cfg;
  logic [NCH-1:0]  hw_en, pend;

  int nchk = 0;
  int nerr = 0;
  int start_cnt = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  dma_trig_seq #(.NCH(NCH), .CFGW(CFGW)) u_dma_trig_seq (
    .clk(clk), .rst_n(rst_n), .sw_trig(sw_trig), .hw_req(hw_req),
    .en_set(en_set), .en_clr(en_clr), .aim(aim), .pkt_we(pkt_we),
    .pkt_sel(pkt_sel), .pkt_data(pkt_data), .blk_done(blk_done),
    .bus_err(bus_err), .start(start), .act_ch(act_ch), .busy(busy),
    .start_cfg(start_cfg), .hw_en(hw_en), .pend(pend)
  );

  always @(posedge clk) if (start) start_cnt++;

  task automatic chk(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_hw(input logic [NCH-1:0] m);
    hw_req = m; step(1); hw_req = '0;
  endtask

  task automatic pulse_sw(input logic [NCH-1:0] m);
    sw_trig = m; step(1); sw_trig = '0;
  endtask

  task automatic pulse_en(input logic [NCH-1:0] s, input logic [NCH-1:0] c);
    en_set = s; en_clr = c; step(1); en_set = '0; en_clr = '0;
  endtask

  task automatic pulse_done();
    blk_done = 1'b1; step(1); blk_done = 1'b0;
  endtask

  task automatic pulse_err();
    bus_err = 1'b1; step(1); bus_err = 1'b0;
  endtask

  task automatic write_pkt(input int ch, input logic [CFGW-1:0] d);
    pkt_we = 1'b1; pkt_sel = CHW'(ch); pkt_data = d; step(1); pkt_we = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 hw_en", int'(hw_en), 0);
    chk("R1 pend", int'(pend), 0);
    chk("R1 busy", int'(busy), 0);
    chk("R1 start", int'(start), 0);
  endtask

  task automatic t_enable();
    pulse_en(4'b0101, 4'b0000);
    chk("R2 set", int'(hw_en), 4'b0101);
    pulse_en(4'b0010, 4'b0001);
    chk("R2 set+clr other bits", int'(hw_en), 4'b0110);
    pulse_en(4'b0100, 4'b0100);
    chk("R2 clear wins", int'(hw_en), 4'b0010);
    pulse_en(4'b0000, 4'b1111);
    chk("R2 clear all", int'(hw_en), 0);
  endtask

  task automatic t_hw_disabled();
    int c0 = start_cnt;
    pulse_hw(4'b0010);
    chk("R3 no pend", int'(pend), 0);
    step(4);
    chk("R3 no start", start_cnt - c0, 0);
    chk("R3 idle", int'(busy), 0);
  endtask

  task automatic t_hw_basic();
    write_pkt(1, 16'hA101);
    aim = 4'b0000;
    pulse_en(4'b0010, 4'b0000);
    pulse_hw(4'b0010);
    chk("R4 pend", int'(pend), 4'b0010);
    step(1);
    chk("R4 busy at grant", int'(busy), 1);
    chk("R4 no early start", int'(start), 0);
    step(1);
    chk("R4 start", int'(start), 1);
    chk("R4 act_ch", int'(act_ch), 1);
    chk("R11 cfg", int'(start_cfg), 16'hA101);
    step(1);
    chk("R4 start one cycle", int'(start), 0);
    chk("R4 busy held", int'(busy), 1);
    pulse_done();
    chk("R5 enable cleared", int'(hw_en), 0);
    chk("R5 idle", int'(busy), 0);
  endtask

  task automatic t_hw_aim();
    int c0;
    aim = 4'b0100;
    pulse_en(4'b0100, 4'b0000);
    pulse_hw(4'b0100);
    step(2);
    chk("R6 start ch2", int'(start) * 16 + int'(act_ch), 16 + 2);
    step(1);
    pulse_done();
    chk("R6 enable kept", int'(hw_en), 4'b0100);
    c0 = start_cnt;
    step(6);
    chk("R6 no restart", start_cnt - c0, 0);
    pulse_hw(4'b0100);
    step(2);
    chk("R6 new request starts", int'(start), 1);
    step(1);
    pulse_done();
    pulse_en(4'b0000, 4'b1111);
    aim = 4'b0000;
  endtask

  task automatic t_sw_aim();
    int c0;
    write_pkt(0, 16'h00C0);
    aim = 4'b0001;
    pulse_sw(4'b0001);
    step(2);
    chk("R7 sw start", int'(start), 1);
    chk("R7 act_ch", int'(act_ch), 0);
    chk("R11 cfg first", int'(start_cfg), 16'h00C0);
    write_pkt(0, 16'h00C1);
    chk("R11 cfg stable", int'(start_cfg), 16'h00C0);
    pulse_done();
    chk("R7 idle after done", int'(busy), 0);
    step(1);
    chk("R7 regranted", int'(busy), 1);
    step(1);
    chk("R7 auto restart", int'(start), 1);
    chk("R11 cfg reloaded", int'(start_cfg), 16'h00C1);
    step(1);
    aim = 4'b0000;
    pulse_done();
    c0 = start_cnt;
    step(6);
    chk("R7 stops without aim", start_cnt - c0, 0);
    chk("R7 nothing pending", int'(pend), 0);
  endtask

  task automatic t_bus_err();
    int c0;
    aim = 4'b1001;
    pulse_en(4'b1000, 4'b0000);
    pulse_hw(4'b1000);
    step(2);
    chk("R8 start ch3", int'(act_ch), 3);
    pulse_hw(4'b1000);
    pulse_err();
    chk("R8 enable cleared", int'(hw_en), 0);
    chk("R8 idle", int'(busy), 0);
    chk("R8 pending dropped", int'(pend), 0);
    pulse_sw(4'b0001);
    step(2);
    chk("R8 sw start", int'(start), 1);
    step(1);
    pulse_err();
    c0 = start_cnt;
    step(6);
    chk("R8 no auto restart", start_cnt - c0, 0);
    aim = 4'b0000;
  endtask

  task automatic t_pending();
    int c0;
    aim = 4'b0010;
    pulse_en(4'b0010, 4'b0000);
    pulse_hw(4'b0010);
    step(2);
    pulse_hw(4'b0010);
    chk("R9 held while busy", int'(pend), 4'b0010);
    pulse_done();
    step(1);
    chk("R9 pending granted", int'(busy), 1);
    step(1);
    chk("R9 pending started", int'(start), 1);
    step(1);
    pulse_done();
    aim = 4'b0000;
    pulse_hw(4'b0010);
    step(2);
    pulse_hw(4'b0010);
    pulse_done();
    chk("R9 enable dropped", int'(hw_en), 0);
    chk("R9 pending discarded", int'(pend), 0);
    c0 = start_cnt;
    step(5);
    chk("R9 no start after discard", start_cnt - c0, 0);
  endtask

  task automatic t_priority();
    aim = 4'b1110;
    pulse_en(4'b1110, 4'b0000);
    pulse_hw(4'b1110);
    step(2);
    chk("R10 lowest first", int'(act_ch), 1);
    step(1);
    pulse_done();
    step(2);
    chk("R10 second", int'(start) * 16 + int'(act_ch), 16 + 2);
    step(1);
    pulse_done();
    step(2);
    chk("R10 third", int'(start) * 16 + int'(act_ch), 16 + 3);
    step(1);
    pulse_done();
    chk("R10 all served", int'(pend), 0);
    pulse_en(4'b0000, 4'b1111);
    aim = 4'b0000;
  endtask

  task automatic t_ignore();
    pulse_en(4'b0010, 4'b0000);
    pulse_done();
    chk("R12 done ignored", int'(hw_en), 4'b0010);
    pulse_err();
    chk("R12 err ignored", int'(hw_en), 4'b0010);
    chk("R12 still idle", int'(busy), 0);
    pulse_en(4'b0000, 4'b1111);
  endtask

  initial begin
    rst_n = 1'b0;
    sw_trig = '0; hw_req = '0; en_set = '0; en_clr = '0; aim = '0;
    pkt_we = 1'b0; pkt_sel = '0; pkt_data = '0;
    blk_done = 1'b0; bus_err = 1'b0;
    step(3);
    t_reset();
    rst_n = 1'b1;
    step(2);
    t_reset();
    t_enable();
    t_hw_disabled();
    t_hw_basic();
    t_hw_aim();
    t_sw_aim();
    t_bus_err();
    t_pending();
    t_priority();
    t_ignore();
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      nchk++;
      nerr++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

endmodule